// File: doc/BRIEF.md
# Segmented DAC Switch Decoder with Rotating Calibration

This block turns a 16-bit two's complement audio sample into the switch pattern for a segmented current-steering converter. The converter has 33 physical unit current sources. At any moment one of them is out of service for recalibration, which leaves 32 for conversion. The upper five bits of the offset code set how many whole sources are steered to the output. One more source feeds an 11-bit binary divider, and the lower eleven bits drive that divider.

A round-robin pointer chooses the source under calibration and moves on each calibration tick. The 32 remaining sources are numbered logically by skipping the pointer position. Logical sources below the coarse count are switched on, and the logical source equal to the coarse count feeds the divider.

The offset is chosen so that code zero lands at divider mid-scale. Small signals around zero therefore change only the divider code and never the whole-source switches. All outputs are registered and update on the clock edge that samples a load strobe or a calibration tick.

Top module: `sdac_switch_decoder`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and sets the calibration pointer to 0.
- R2: On a load, the offset value is formed as u = x + 33792, where x is the signed sample, and is clamped to 65535. The number of whole sources switched on equals u / 2048 (bits 15..11), and the divider code output equals u mod 2048 (bits 10..0).
- R3: Every sample from -1024 to +1023 gives exactly 16 whole sources on, with the same switch vector. Samples 0 and -1 give divider codes 1024 and 1023. Sample -1025 gives 15 sources on and code 2047.
- R4: Each calibration tick advances the pointer by one modulo 33 (32 goes to 0). After any event, the calibrate select output is one-hot at the pointer's physical index.
- R5: The source under calibration never has its output switch or its divider-feed bit set.
- R6: A physical source p below the pointer has logical index p, and one above the pointer has logical index p-1. A source is on when its logical index is below the coarse count, and it feeds the divider when its logical index equals the coarse count.
- R7: A change of the sample input without a load strobe has no effect on any output.
- R8: When a tick and a load fall in the same cycle, the pointer advances first and the new sample is mapped around the new pointer.
- R9: After a load, exactly one source feeds the divider. The count of sources on times 2048, plus the divider code, equals the clamped u.
- R10: Before the first load, the switch, divider-feed and divider-code outputs stay zero; ticks move only the calibrate select.
- R11: The outputs change only on the edge that samples a load or a tick, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 16 | Two's complement audio sample |
| load_i | input | 1 | Strobe that takes sample_i |
| cal_tick_i | input | 1 | Advances the calibration pointer |
| src_on_o | output | 33 | Per physical source: steered to the output |
| div_feed_o | output | 33 | One-hot: physical source feeding the divider |
| cal_sel_o | output | 33 | One-hot: physical source under calibration |
| div_code_o | output | 11 | Binary divider code |

## Verification
A calibration tick and a sample load can arrive in the same clock cycle. In that case the new pointer must be in place before the new sample is mapped onto the sources. The bench provokes this by raising both strobes together at several pointer positions, including the wrap from 32 to 0. It judges the result by comparing every output vector with a model that advances the pointer first and then places the whole sources and the divider feed around it. It also confirms the calibrated source is isolated and the total current still equals the clamped offset value.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int SAMPLE_W = 16;
    localparam int FINE_W   = 11;
    localparam int COARSE_W = SAMPLE_W - FINE_W;
    localparam int N_ACTIVE = 2 ** COARSE_W;
    localparam int N_SRC    = N_ACTIVE + 1;
    localparam int PTR_W    = $clog2(N_SRC);

    // offset: half the signed range plus half the divider range
    localparam logic [SAMPLE_W:0] LEVEL_OFFSET =
        (SAMPLE_W+1)'((1 << (SAMPLE_W-1)) + (1 << (FINE_W-1)));

    typedef logic [PTR_W-1:0]    ptr_t;
    typedef logic [COARSE_W-1:0] coarse_t;
    typedef logic [FINE_W-1:0]   fine_t;
    typedef logic [N_SRC-1:0]    src_vec_t;

    typedef struct packed {
        coarse_t coarse;
        fine_t   fine;
    } level_t;

    typedef struct packed {
        src_vec_t on;
        src_vec_t feed;
        src_vec_t cal;
        fine_t    code;
    } drive_t;

    function automatic level_t decode_level(input logic [SAMPLE_W-1:0] s);
        logic [SAMPLE_W:0] u;
        level_t r;
        u = {s[SAMPLE_W-1], s} + LEVEL_OFFSET;
        if (u[SAMPLE_W]) r = '1;
        else             r = u[SAMPLE_W-1:0];
        return r;
    endfunction

    function automatic ptr_t advance_ptr(input ptr_t p);
        if (p == PTR_W'(N_SRC-1)) return '0;
        return p + 1'b1;
    endfunction
endpackage

// File: rtl/sdac_cal_rotator.sv
module sdac_cal_rotator
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output ptr_t ptr_next_o
);
    ptr_t ptr_q;

    always_comb ptr_next_o = tick_i ? advance_ptr(ptr_q) : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_next_o;
    end

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ptr_q == PTR_W'(N_SRC-1)) |=> (ptr_q == '0));
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ptr_q < PTR_W'(N_SRC-1)) |=> (ptr_q == $past(ptr_q) + 1'b1));
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
        ptr_q < PTR_W'(N_SRC));
endmodule

// File: rtl/sdac_level_reg.sv
module sdac_level_reg
    import sdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output level_t              level_next_o,
    output logic                primed_next_o
);
    level_t level_q;
    logic   primed_q;

    always_comb begin
        level_next_o  = load_i ? decode_level(sample_i) : level_q;
        primed_next_o = primed_q | load_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            primed_q <= 1'b0;
        end else begin
            level_q  <= level_next_o;
            primed_q <= primed_next_o;
        end
    end

    assert_zero_band_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && ($signed(sample_i) >= -1024) && ($signed(sample_i) <= 1023))
        |=> (level_q.coarse == COARSE_W'(N_ACTIVE/2)));
    assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(level_q));
endmodule

// File: rtl/sdac_source_map.sv
module sdac_source_map
    import sdac_pkg::*;
(
    input  ptr_t   ptr_i,
    input  level_t level_i,
    input  logic   primed_i,
    output drive_t drive_o
);
    src_vec_t on_v, feed_v, cal_v;
    ptr_t     coarse_ext;

    assign coarse_ext = PTR_W'(level_i.coarse);

    for (genvar p = 0; p < N_SRC; p++) begin : g_src
        localparam ptr_t PIDX = PTR_W'(p);
        ptr_t lidx;
        logic usable;
        // skip the source under calibration when numbering logically
        assign lidx   = (PIDX < ptr_i) ? PIDX : PIDX - 1'b1;
        assign usable = primed_i && (PIDX != ptr_i);
        assign on_v[p]   = usable && (lidx < coarse_ext);
        assign feed_v[p] = usable && (lidx == coarse_ext);
        assign cal_v[p]  = (PIDX == ptr_i);
    end

    always_comb begin
        drive_o.on   = on_v;
        drive_o.feed = feed_v;
        drive_o.cal  = cal_v;
        drive_o.code = primed_i ? level_i.fine : '0;
    end
endmodule

// File: rtl/sdac_switch_decoder.sv
module sdac_switch_decoder
    import sdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                load_i,
    input  logic                cal_tick_i,
    output logic [N_SRC-1:0]    src_on_o,
    output logic [N_SRC-1:0]    div_feed_o,
    output logic [N_SRC-1:0]    cal_sel_o,
    output logic [FINE_W-1:0]   div_code_o
);
    ptr_t   ptr_next;
    level_t level_next;
    logic   primed_next;
    drive_t drive_next, drive_q;

    sdac_cal_rotator u_rot (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (cal_tick_i),
        .ptr_next_o (ptr_next)
    );

    sdac_level_reg u_lvl (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load_i),
        .sample_i      (sample_i),
        .level_next_o  (level_next),
        .primed_next_o (primed_next)
    );

    sdac_source_map u_map (
        .ptr_i    (ptr_next),
        .level_i  (level_next),
        .primed_i (primed_next),
        .drive_o  (drive_next)
    );

    always_ff @(posedge clk) begin
        if (rst)                      drive_q <= '0;
        else if (load_i || cal_tick_i) drive_q <= drive_next;
    end

    assign src_on_o   = drive_q.on;
    assign div_feed_o = drive_q.feed;
    assign cal_sel_o  = drive_q.cal;
    assign div_code_o = drive_q.code;

    assert_cal_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cal_sel_o));
    assert_cal_isolated_R5: assert property (@(posedge clk) disable iff (rst)
        (cal_sel_o & (src_on_o | div_feed_o)) == '0);
    assert_feed_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(div_feed_o));
    assert_feed_apart_R6: assert property (@(posedge clk) disable iff (rst)
        (src_on_o & div_feed_o) == '0);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (div_feed_o == '0) |-> (src_on_o == '0 && div_code_o == '0));
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(load_i || cal_tick_i) |=> ($stable(src_on_o) && $stable(div_feed_o)
                                     && $stable(cal_sel_o) && $stable(div_code_o)));
endmodule

// File: tb/sdac_switch_decoder_tb.sv
module sdac_switch_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sample_i = '0;
    logic        load_i = 1'b0;
    logic        cal_tick_i = 1'b0;
    logic [32:0] src_on_o, div_feed_o, cal_sel_o;
    logic [10:0] div_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model state
    int  mptr = 0, mcoarse = 0, mfine = 0;
    bit  mprimed = 0;

    sdac_switch_decoder u_dut (
        .clk(clk), .rst(rst), .sample_i(sample_i), .load_i(load_i),
        .cal_tick_i(cal_tick_i), .src_on_o(src_on_o), .div_feed_o(div_feed_o),
        .cal_sel_o(cal_sel_o), .div_code_o(div_code_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clamp_u(input int x);
        int u = x + 33792;
        return (u > 65535) ? 65535 : u;
    endfunction

    // expected outputs from R2, R4, R6, R10
    task automatic check_model(input string req);
        logic [32:0] eon = '0, efeed = '0, ecal = '0;
        for (int p = 0; p < 33; p++) begin
            int l = (p < mptr) ? p : p - 1;
            if (p == mptr) ecal[p] = 1'b1;
            else if (mprimed) begin
                if (l < mcoarse)  eon[p] = 1'b1;
                if (l == mcoarse) efeed[p] = 1'b1;
            end
        end
        check({req, " switches"}, 64'(src_on_o), 64'(eon));
        check({req, " feed"},     64'(div_feed_o), 64'(efeed));
        check({req, " cal"},      64'(cal_sel_o), 64'(ecal));
        check({req, " code"},     64'(div_code_o), mprimed ? 64'(mfine) : 64'd0);
    endtask

    task automatic step(input bit ld, input bit tk, input int x);
        @(negedge clk);
        load_i = ld; cal_tick_i = tk; sample_i = 16'(x);
        @(negedge clk);
        load_i = 0; cal_tick_i = 0;
        if (tk) mptr = (mptr == 32) ? 0 : mptr + 1;
        if (ld) begin
            int u = clamp_u(x);
            mcoarse = u / 2048; mfine = u % 2048; mprimed = 1;
        end
    endtask

    task automatic check_total(input string req, input int x);
        check({req, " total"}, 64'($countones(src_on_o) * 2048 + int'(div_code_o)), 64'(clamp_u(x)));
        check({req, " feed count"}, 64'($countones(div_feed_o)), 64'd1);
    endtask

    task automatic t_reset;
        check("R1 reset switches", 64'(src_on_o), 0);
        check("R1 reset feed", 64'(div_feed_o), 0);
        check("R1 reset cal", 64'(cal_sel_o), 0);
        check("R1 reset code", 64'(div_code_o), 0);
    endtask

    task automatic t_idle_tick;
        step(0, 1, 0);
        check("R10 idle cal", 64'(cal_sel_o), 64'(33'd1 << 1));
        check("R10 idle switches", 64'(src_on_o | div_feed_o), 0);
        check_model("R10");
    endtask

    task automatic t_zero_band;
        logic [32:0] ref_on;
        step(1, 0, 0);
        check_model("R3 zero");
        check("R3 zero code", 64'(div_code_o), 64'd1024);
        check("R2 zero count", 64'($countones(src_on_o)), 64'd16);
        ref_on = src_on_o;
        step(1, 0, -1);
        check("R3 minus one switches", 64'(src_on_o), 64'(ref_on));
        check("R3 minus one code", 64'(div_code_o), 64'd1023);
        step(1, 0, -1024);
        check("R3 low edge switches", 64'(src_on_o), 64'(ref_on));
        check("R3 low edge code", 64'(div_code_o), 64'd0);
        step(1, 0, 1023);
        check("R3 high edge switches", 64'(src_on_o), 64'(ref_on));
        check("R3 high edge code", 64'(div_code_o), 64'd2047);
        step(1, 0, -1025);
        check("R3 below band count", 64'($countones(src_on_o)), 64'd15);
        check("R3 below band code", 64'(div_code_o), 64'd2047);
        check_model("R6 below band");
    endtask

    task automatic t_ignore;
        logic [32:0] on0 = src_on_o;
        logic [10:0] c0  = div_code_o;
        @(negedge clk); sample_i = 16'h7abc;
        @(negedge clk); @(negedge clk);
        check("R7 ignored switches", 64'(src_on_o), 64'(on0));
        check("R7 ignored code", 64'(div_code_o), 64'(c0));
        check("R11 hold", 64'(div_code_o), 64'(mfine));
    endtask

    task automatic t_rotate;
        step(1, 0, 5000);
        for (int i = 0; i < 34; i++) begin
            step(0, 1, 0);
            check_model("R4 rotate");
            check("R5 isolation", 64'(cal_sel_o & (src_on_o | div_feed_o)), 0);
            check_total("R9 rotate", 5000);
        end
    endtask

    task automatic t_same_cycle;
        int xs[4] = '{-20000, 12345, 0, 30000};
        while (mptr != 31) step(0, 1, 0);
        for (int i = 0; i < 4; i++) begin
            step(1, 1, xs[i]);
            check_model("R8 tick with load");
            check_total("R8", xs[i]);
        end
    endtask

    task automatic t_clamp;
        int xs[5] = '{32767, 31743, 31744, -32768, -32767};
        for (int i = 0; i < 5; i++) begin
            step(1, 0, xs[i]);
            check_model("R2 clamp");
            check_total("R9 clamp", xs[i]);
        end
        step(1, 0, 32767);
        check("R2 top count", 64'($countones(src_on_o)), 64'd31);
        check("R2 top code", 64'(div_code_o), 64'd2047);
    endtask

    task automatic t_patterns;
        logic [15:0] lf = 16'hace1;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(1, (i % 3) == 0, int'($signed(lf)));
            check_model("R6 pattern");
            check_total("R9 pattern", int'($signed(lf)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_idle_tick();
        t_zero_band();
        t_ignore();
        t_rotate();
        t_same_cycle();
        t_clamp();
        t_patterns();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule